// File: doc/BRIEF.md
# Unified Data Space Address Router

This block takes one 16-bit data-space address and steers the access to one of three internal stores. The stores are a 32-entry working register file, a 64-entry I/O register bank and a 1024-byte SRAM. Data-space addresses run upward through the register file first, then the I/O bank, then the SRAM. An address beyond the last SRAM byte reaches no store.

A second, narrow port reaches the I/O bank directly with a 6-bit I/O number, as short-form I/O move instructions do. Through the wide data-space port, the same I/O register sits 0x20 higher than its I/O number. A third port sets or clears one bit of an I/O register in a single read-modify-write cycle. That bit port only works on the lower half of the I/O bank.

All three ports share the stores. A fixed priority picks one of them per cycle. Read results are registered and appear on the output one cycle after the request.

Top module: `dspace_router`

## Requirements
- R1: While reset is held, and after it is released, `ds_rdata`, `io_rdata`, `oor_flag` and `bit_err` are 0. Every register-file and I/O-bank entry reads back as 0x00 until it is written.
- R2: A data-space address 0x0000 to 0x001F selects register-file entry `addr`. `sel_rf` is high in the request cycle, and a write there can be read back at the same address.
- R3: A data-space address 0x0020 to 0x005F selects I/O register `addr - 0x20`, with `sel_io` high. This is the same storage that the I/O port reaches with I/O number `addr - 0x20`.
- R4: A data-space address 0x0060 to 0x045F selects SRAM byte `addr - 0x60`, with `sel_sram` high. Writes there can be read back.
- R5: At most one of `sel_rf`, `sel_io`, `sel_sram` is high, and only while `ds_req` is high. All three are low for addresses above 0x045F.
- R6: A data-space read above 0x045F returns 0x00 on `ds_rdata` and sets `oor_flag` for exactly the following cycle. A write above 0x045F changes no location in any store.
- R7: The I/O port (`io_req`, `io_we`, 6-bit `io_addr`) reads and writes I/O register `io_addr`. A read result appears on `io_rdata` the cycle after the request.
- R8: A granted bit operation with `bit_addr` 0x00 to 0x1F changes only bit `bit_idx` (0 = LSB) of that I/O register. `bit_set`=1 sets the bit and `bit_set`=0 clears it. The new value is visible to a read issued in the next cycle.
- R9: A granted bit operation with `bit_addr` 0x20 to 0x3F leaves the register unchanged and raises `bit_err` for exactly the following cycle.
- R10: Only one port is served per cycle, in the order data-space port, then I/O port, then bit port. A losing request has no effect on any store or output.
- R11: `ds_rdata` changes only in the cycle after a granted data-space read. `io_rdata` changes only in the cycle after a granted I/O-port read. Writes leave both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ds_req | input | 1 | Data-space access request |
| ds_we | input | 1 | Data-space access is a write |
| ds_addr | input | 16 | Data-space byte address |
| ds_wdata | input | 8 | Data-space write data |
| io_req | input | 1 | Short I/O port request |
| io_we | input | 1 | Short I/O access is a write |
| io_addr | input | 6 | I/O register number |
| io_wdata | input | 8 | Short I/O write data |
| bit_req | input | 1 | Single-bit operation request |
| bit_set | input | 1 | 1 sets the bit, 0 clears it |
| bit_addr | input | 6 | I/O register number for the bit operation |
| bit_idx | input | 3 | Bit position within the register |
| ds_rdata | output | 8 | Registered data-space read result |
| io_rdata | output | 8 | Registered short I/O read result |
| sel_rf | output | 1 | Current data-space access targets the register file |
| sel_io | output | 1 | Current data-space access targets the I/O bank |
| sel_sram | output | 1 | Current data-space access targets the SRAM |
| oor_flag | output | 1 | Previous data-space read was out of range |
| bit_err | output | 1 | Previous bit operation addressed a register without bit access |

## Verification
The assertions assume that a request is held for a full clock period. They also assume that every request input is at a defined level from reset release onward, so the priority and select checks always see 0 or 1. The bench drives every input on the falling edge, parks all requests at 0 between operations, and raises several requests in the same cycle only in the scenario built to exercise the priority order. SRAM bytes come out of reset undefined, so the bench reads only SRAM bytes it has written earlier in the run.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_RF   = 2'd1,
    RGN_IO   = 2'd2,
    RGN_SRAM = 2'd3
  } dsr_region_e;

endpackage

// File: rtl/dsr_rst_sync.sv
module dsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dsr_decode.sv
module dsr_decode
  import dsr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int RF_DEPTH   = 32,
  parameter int IO_DEPTH   = 64,
  parameter int SRAM_DEPTH = 1024,
  localparam int RF_AW     = $clog2(RF_DEPTH),
  localparam int IO_AW     = $clog2(IO_DEPTH),
  localparam int SRAM_AW   = $clog2(SRAM_DEPTH)
) (
  input  logic [ADDR_W-1:0]  addr,
  output dsr_region_e        region,
  output logic [RF_AW-1:0]   rf_off,
  output logic [IO_AW-1:0]   io_off,
  output logic [SRAM_AW-1:0] sram_off
);

  // region boundaries, laid end to end from address zero
  localparam logic [ADDR_W-1:0] IO_BASE   = ADDR_W'(RF_DEPTH);
  localparam logic [ADDR_W-1:0] SRAM_BASE = ADDR_W'(RF_DEPTH + IO_DEPTH);
  localparam logic [ADDR_W-1:0] SRAM_END  = ADDR_W'(RF_DEPTH + IO_DEPTH + SRAM_DEPTH);

  always_comb begin
    if (addr < IO_BASE) begin
      region = RGN_RF;
    end else if (addr < SRAM_BASE) begin
      region = RGN_IO;
    end else if (addr < SRAM_END) begin
      region = RGN_SRAM;
    end else begin
      region = RGN_NONE;
    end
  end

  // local offsets inside each store
  assign rf_off   = addr[RF_AW-1:0];
  assign io_off   = IO_AW'(addr - IO_BASE);
  assign sram_off = SRAM_AW'(addr - SRAM_BASE);

endmodule

// File: rtl/dsr_store.sv
module dsr_store #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 32,
  parameter bit HAS_RST = 1'b1,
  parameter bit BIT_OPS = 1'b0,
  localparam int AW     = $clog2(DEPTH),
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              bop_en,
  input  logic [AW-1:0]     bop_addr,
  input  logic [IDX_W-1:0]  bop_idx,
  input  logic              bop_set
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] bop_cur;
  logic [DATA_W-1:0] bop_mask;
  logic [DATA_W-1:0] bop_val;
  logic [DATA_W-1:0] entry_val;
  logic              bop_hit;

  assign bop_hit = BIT_OPS && bop_en;

  // read-modify-write value for a bit operation
  always_comb begin
    bop_cur  = mem[bop_addr];
    bop_mask = DATA_W'(1) << bop_idx;
    bop_val  = bop_set ? (bop_cur | bop_mask) : (bop_cur & ~bop_mask);
  end

  // a word write and a bit operation are never granted together
  assign entry_val = we ? wdata : bop_val;

  assign rdata = mem[raddr];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    logic entry_en;

    always_comb begin
      entry_en = (we && (waddr == AW'(gi))) || (bop_hit && (bop_addr == AW'(gi)));
    end

    if (HAS_RST) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem[gi] <= '0;
        end else if (entry_en) begin
          mem[gi] <= entry_val;
        end
      end
    end else begin : g_norst
      always_ff @(posedge clk) begin
        if (entry_en) begin
          mem[gi] <= entry_val;
        end
      end
    end
  end

  // R8: a bit operation alters at most one bit of the addressed entry
  a_r8_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bop_hit && !we) |=> ($countones(mem[$past(bop_addr)] ^ $past(bop_cur)) <= 1));

  // R8: the addressed bit ends at the requested level
  a_r8_bit_level: assert property (@(posedge clk) disable iff (!rst_n)
    (bop_hit && !we) |=> (mem[$past(bop_addr)][$past(bop_idx)] == $past(bop_set)));

endmodule

// File: rtl/dspace_router.sv
module dspace_router
  import dsr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RF_DEPTH   = 32,
  parameter int IO_DEPTH   = 64,
  parameter int SRAM_DEPTH = 1024,
  parameter int BIT_LIMIT  = 32,
  localparam int IO_AW     = $clog2(IO_DEPTH),
  localparam int IDX_W     = $clog2(DATA_W),
  localparam int RF_AW     = $clog2(RF_DEPTH),
  localparam int SRAM_AW   = $clog2(SRAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ds_req,
  input  logic              ds_we,
  input  logic [ADDR_W-1:0] ds_addr,
  input  logic [DATA_W-1:0] ds_wdata,
  input  logic              io_req,
  input  logic              io_we,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              bit_req,
  input  logic              bit_set,
  input  logic [IO_AW-1:0]  bit_addr,
  input  logic [IDX_W-1:0]  bit_idx,
  output logic [DATA_W-1:0] ds_rdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              sel_rf,
  output logic              sel_io,
  output logic              sel_sram,
  output logic              oor_flag,
  output logic              bit_err
);

  localparam logic [ADDR_W-1:0] SRAM_END  = ADDR_W'(RF_DEPTH + IO_DEPTH + SRAM_DEPTH);
  localparam logic [IO_AW-1:0]  BIT_TOP   = IO_AW'(BIT_LIMIT);

  logic rst_i_n;

  dsr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // ---------------- port arbitration ----------------
  logic grant_ds, grant_io, grant_bit;
  logic ds_rd, io_rd, bit_ok, bit_bad;

  always_comb begin
    grant_ds  = ds_req;
    grant_io  = io_req && !ds_req;
    grant_bit = bit_req && !ds_req && !io_req;
    ds_rd     = grant_ds && !ds_we;
    io_rd     = grant_io && !io_we;
    bit_ok    = grant_bit && (bit_addr < BIT_TOP);
    bit_bad   = grant_bit && (bit_addr >= BIT_TOP);
  end

  // ---------------- decode ----------------
  dsr_region_e        region;
  logic [RF_AW-1:0]   rf_off;
  logic [IO_AW-1:0]   io_off;
  logic [SRAM_AW-1:0] sram_off;

  dsr_decode #(
    .ADDR_W     (ADDR_W),
    .RF_DEPTH   (RF_DEPTH),
    .IO_DEPTH   (IO_DEPTH),
    .SRAM_DEPTH (SRAM_DEPTH)
  ) u_dec (
    .addr     (ds_addr),
    .region   (region),
    .rf_off   (rf_off),
    .io_off   (io_off),
    .sram_off (sram_off)
  );

  always_comb begin
    sel_rf   = grant_ds && (region == RGN_RF);
    sel_io   = grant_ds && (region == RGN_IO);
    sel_sram = grant_ds && (region == RGN_SRAM);
  end

  // ---------------- stores ----------------
  logic [DATA_W-1:0] rf_q, io_q, sram_q;
  logic              io_we_mux;
  logic [IO_AW-1:0]  io_idx;
  logic [DATA_W-1:0] io_wd;

  always_comb begin
    io_we_mux = (sel_io && ds_we) || (grant_io && io_we);
    io_idx    = sel_io ? io_off : io_addr;
    io_wd     = sel_io ? ds_wdata : io_wdata;
  end

  dsr_store #(
    .DATA_W (DATA_W), .DEPTH (RF_DEPTH), .HAS_RST (1'b1), .BIT_OPS (1'b0)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .we       (sel_rf && ds_we),
    .waddr    (rf_off),
    .wdata    (ds_wdata),
    .raddr    (rf_off),
    .rdata    (rf_q),
    .bop_en   (1'b0),
    .bop_addr ('0),
    .bop_idx  ('0),
    .bop_set  (1'b0)
  );

  dsr_store #(
    .DATA_W (DATA_W), .DEPTH (IO_DEPTH), .HAS_RST (1'b1), .BIT_OPS (1'b1)
  ) u_io (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .we       (io_we_mux),
    .waddr    (io_idx),
    .wdata    (io_wd),
    .raddr    (io_idx),
    .rdata    (io_q),
    .bop_en   (bit_ok),
    .bop_addr (bit_addr),
    .bop_idx  (bit_idx),
    .bop_set  (bit_set)
  );

  dsr_store #(
    .DATA_W (DATA_W), .DEPTH (SRAM_DEPTH), .HAS_RST (1'b0), .BIT_OPS (1'b0)
  ) u_sram (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .we       (sel_sram && ds_we),
    .waddr    (sram_off),
    .wdata    (ds_wdata),
    .raddr    (sram_off),
    .rdata    (sram_q),
    .bop_en   (1'b0),
    .bop_addr ('0),
    .bop_idx  ('0),
    .bop_set  (1'b0)
  );

  // ---------------- registered results ----------------
  logic [DATA_W-1:0] ds_rdata_q, ds_rdata_d;
  logic [DATA_W-1:0] io_rdata_q;
  logic              oor_q, oor_d;
  logic              berr_q;

  always_comb begin
    unique case (region)
      RGN_RF:   ds_rdata_d = rf_q;
      RGN_IO:   ds_rdata_d = io_q;
      RGN_SRAM: ds_rdata_d = sram_q;
      default:  ds_rdata_d = '0;
    endcase
    oor_d = ds_rd && (region == RGN_NONE);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ds_rdata_q <= '0;
    end else if (ds_rd) begin
      ds_rdata_q <= ds_rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      io_rdata_q <= '0;
    end else if (io_rd) begin
      io_rdata_q <= io_q;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      oor_q  <= 1'b0;
      berr_q <= 1'b0;
    end else begin
      oor_q  <= oor_d;
      berr_q <= bit_bad;
    end
  end

  assign ds_rdata = ds_rdata_q;
  assign io_rdata = io_rdata_q;
  assign oor_flag = oor_q;
  assign bit_err  = berr_q;

  // ---------------- assertions ----------------
  // R5: selects are exclusive
  a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({sel_rf, sel_io, sel_sram}));

  // R5: a select needs a data-space request
  a_r5_sel_needs_req: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sel_rf || sel_io || sel_sram) |-> ds_req);

  // R6: an out-of-range read yields the flag next cycle
  a_r6_oor_flag: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ds_req && !ds_we && (ds_addr >= SRAM_END)) |=> oor_flag);

  // R6: with the flag up, read data is zero
  a_r6_oor_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    oor_flag |-> (ds_rdata == '0));

  // R9: a bit request above the limit, when granted, raises the error
  a_r9_bit_err: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bit_req && !ds_req && !io_req && (bit_addr >= BIT_TOP)) |=> bit_err);

  // R10: an I/O-port read losing to the data-space port leaves its result
  a_r10_io_blocked: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ds_req && io_req) |=> $stable(io_rdata));

  // R11: data-space result moves only after a data-space read
  a_r11_ds_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(ds_req && !ds_we) |=> $stable(ds_rdata));

  // R11: I/O result moves only after an I/O-port read
  a_r11_io_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(io_req && !io_we) |=> $stable(io_rdata));

endmodule

// File: tb/dspace_router_tb_top.sv
module dspace_router_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       ds_req, ds_we;
  logic [15:0] ds_addr;
  logic [7:0] ds_wdata;
  logic       io_req, io_we;
  logic [5:0] io_addr;
  logic [7:0] io_wdata;
  logic       bit_req, bit_set;
  logic [5:0] bit_addr;
  logic [2:0] bit_idx;
  logic [7:0] ds_rdata, io_rdata;
  logic       sel_rf, sel_io, sel_sram, oor_flag, bit_err;

  int checks = 0;
  int failures = 0;

  dspace_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .ds_req(ds_req), .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
    .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
    .bit_req(bit_req), .bit_set(bit_set), .bit_addr(bit_addr), .bit_idx(bit_idx),
    .ds_rdata(ds_rdata), .io_rdata(io_rdata),
    .sel_rf(sel_rf), .sel_io(sel_io), .sel_sram(sel_sram),
    .oor_flag(oor_flag), .bit_err(bit_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
    end
  endtask

  task automatic idle();
    ds_req = 0; ds_we = 0; io_req = 0; io_we = 0; bit_req = 0;
  endtask

  task automatic ds_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); idle(); ds_req = 1; ds_we = 1; ds_addr = a; ds_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic ds_rd(input logic [15:0] a, output logic [7:0] d, output logic o);
    @(negedge clk); idle(); ds_req = 1; ds_addr = a;
    @(negedge clk); d = ds_rdata; o = oor_flag; idle();
  endtask

  task automatic io_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); idle(); io_req = 1; io_we = 1; io_addr = a; io_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic io_rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); idle(); io_req = 1; io_addr = a;
    @(negedge clk); d = io_rdata; idle();
  endtask

  task automatic bit_op(input logic [5:0] a, input logic [2:0] i, input logic s, output logic e);
    @(negedge clk); idle(); bit_req = 1; bit_addr = a; bit_idx = i; bit_set = s;
    @(negedge clk); e = bit_err; idle();
  endtask

  task automatic t_reset();
    logic [7:0] d; logic o;
    chk("R1 ds_rdata", ds_rdata, 0);
    chk("R1 io_rdata", io_rdata, 0);
    chk("R1 oor_flag", oor_flag, 0);
    chk("R1 bit_err", bit_err, 0);
    ds_rd(16'h0000, d, o); chk("R1 rf[0]", d, 0);
    io_rd(6'h3F, d);       chk("R1 io[3F]", d, 0);
  endtask

  task automatic t_rf();
    logic [7:0] d; logic o;
    @(negedge clk); idle(); ds_req = 1; ds_addr = 16'h001F; #1;
    chk("R2 sel_rf", {sel_rf, sel_io, sel_sram}, 3'b100);
    ds_wr(16'h0000, 8'h3C); ds_wr(16'h001F, 8'hC3);
    ds_rd(16'h0000, d, o); chk("R2 rf[00]", d, 8'h3C);
    ds_rd(16'h001F, d, o); chk("R2 rf[1F]", d, 8'hC3);
  endtask

  task automatic t_io_alias();
    logic [7:0] d; logic o;
    @(negedge clk); idle(); ds_req = 1; ds_addr = 16'h0020; #1;
    chk("R3 sel_io low edge", {sel_rf, sel_io, sel_sram}, 3'b010);
    ds_addr = 16'h005F; #1;
    chk("R3 sel_io high edge", {sel_rf, sel_io, sel_sram}, 3'b010);
    ds_wr(16'h0020, 8'h11); ds_wr(16'h005F, 8'h22);
    io_rd(6'h00, d); chk("R3 io[00] via io port", d, 8'h11);
    io_rd(6'h3F, d); chk("R3 io[3F] via io port", d, 8'h22);
    io_wr(6'h10, 8'h5E);
    ds_rd(16'h0030, d, o); chk("R3 io[10] via data space", d, 8'h5E);
  endtask

  task automatic t_sram();
    logic [7:0] d; logic o;
    @(negedge clk); idle(); ds_req = 1; ds_addr = 16'h0060; #1;
    chk("R4 sel_sram low edge", {sel_rf, sel_io, sel_sram}, 3'b001);
    ds_addr = 16'h045F; #1;
    chk("R4 sel_sram high edge", {sel_rf, sel_io, sel_sram}, 3'b001);
    ds_addr = 16'h0460; #1;
    chk("R5 no select out of range", {sel_rf, sel_io, sel_sram}, 3'b000);
    ds_req = 0; ds_addr = 16'h0001; #1;
    chk("R5 no select without req", {sel_rf, sel_io, sel_sram}, 3'b000);
    ds_wr(16'h0060, 8'hA1); ds_wr(16'h045F, 8'hB2); ds_wr(16'h0200, 8'hC4);
    ds_rd(16'h0060, d, o); chk("R4 sram[0]", d, 8'hA1);
    ds_rd(16'h045F, d, o); chk("R4 sram[3FF]", d, 8'hB2);
    chk("R6 no flag in range", o, 0);
    ds_rd(16'h0200, d, o); chk("R4 sram mid", d, 8'hC4);
  endtask

  task automatic t_oor();
    logic [7:0] d; logic o;
    ds_wr(16'h0460, 8'h99);
    ds_wr(16'hFFFF, 8'h98);
    ds_rd(16'h0060, d, o); chk("R6 write dropped sram[0]", d, 8'hA1);
    ds_rd(16'h0000, d, o); chk("R6 write dropped rf[00]", d, 8'h3C);
    ds_rd(16'h0020, d, o); chk("R6 write dropped io[00]", d, 8'h11);
    ds_rd(16'h045F, d, o); chk("R6 write dropped sram top", d, 8'hB2);
    ds_rd(16'h0460, d, o); chk("R6 oor data", d, 0); chk("R6 oor flag", o, 1);
    @(negedge clk); chk("R6 flag one cycle", oor_flag, 0);
    ds_rd(16'h0001, d, o);
    ds_rd(16'hFFFF, d, o); chk("R6 oor data max", d, 0); chk("R6 oor flag max", o, 1);
  endtask

  task automatic t_ioport();
    logic [7:0] d; logic o;
    ds_rd(16'h0000, d, o);
    io_wr(6'h07, 8'h6D);
    io_rd(6'h07, d); chk("R7 io read", d, 8'h6D);
    chk("R7 ds_rdata untouched", ds_rdata, 8'h3C);
  endtask

  task automatic t_bitop();
    logic [7:0] d; logic e;
    io_wr(6'h03, 8'hA5);
    bit_op(6'h03, 3'd1, 1'b1, e); io_rd(6'h03, d); chk("R8 set bit1", d, 8'hA7);
    chk("R8 no error", e, 0);
    bit_op(6'h03, 3'd7, 1'b0, e); io_rd(6'h03, d); chk("R8 clear bit7", d, 8'h27);
    bit_op(6'h03, 3'd0, 1'b1, e); io_rd(6'h03, d); chk("R8 set already set", d, 8'h27);
    io_wr(6'h1F, 8'h00);
    bit_op(6'h1F, 3'd4, 1'b1, e); io_rd(6'h1F, d); chk("R8 top bit-capable reg", d, 8'h10);
  endtask

  task automatic t_biterr();
    logic [7:0] d; logic e;
    io_wr(6'h22, 8'h3C);
    bit_op(6'h22, 3'd0, 1'b1, e); chk("R9 bit_err raised", e, 1);
    @(negedge clk); chk("R9 bit_err one cycle", bit_err, 0);
    io_rd(6'h22, d); chk("R9 register unchanged", d, 8'h3C);
    bit_op(6'h20, 3'd2, 1'b0, e); chk("R9 bit_err at 0x20", e, 1);
  endtask

  task automatic t_priority();
    logic [7:0] d; logic o;
    @(negedge clk); idle();
    ds_req = 1; ds_we = 1; ds_addr = 16'h0025; ds_wdata = 8'hAA;
    io_req = 1; io_we = 1; io_addr = 6'h05; io_wdata = 8'h55;
    bit_req = 1; bit_addr = 6'h05; bit_idx = 3'd0; bit_set = 1;
    @(negedge clk); idle();
    io_rd(6'h05, d); chk("R10 ds wins", d, 8'hAA);
    @(negedge clk); idle();
    io_req = 1; io_we = 1; io_addr = 6'h06; io_wdata = 8'h0F;
    bit_req = 1; bit_addr = 6'h06; bit_idx = 3'd7; bit_set = 1;
    @(negedge clk); idle();
    io_rd(6'h06, d); chk("R10 io beats bit", d, 8'h0F);
    @(negedge clk); idle();
    ds_req = 1; ds_addr = 16'h0000; io_req = 1; io_addr = 6'h07;
    @(negedge clk); idle();
    chk("R10 ds read served", ds_rdata, 8'h3C);
    chk("R10 io read blocked", io_rdata, 8'h0F);
    @(negedge clk); idle();
    io_req = 1; io_addr = 6'h22; bit_req = 1; bit_addr = 6'h22;
    @(negedge clk); idle();
    chk("R10 bit loses, no error", bit_err, 0);
    ds_rd(16'h0000, d, o);
  endtask

  task automatic t_hold();
    logic [7:0] d; logic o;
    ds_wr(16'h0001, 8'h5A);
    ds_rd(16'h0001, d, o); chk("R11 read value", d, 8'h5A);
    ds_wr(16'h0001, 8'h00);
    chk("R11 ds_rdata held over write", ds_rdata, 8'h5A);
    io_rd(6'h07, d);
    io_wr(6'h07, 8'h01);
    chk("R11 io_rdata held over write", io_rdata, 8'h6D);
    repeat (3) @(negedge clk);
    chk("R11 ds_rdata held idle", ds_rdata, 8'h5A);
  endtask

  initial begin
    idle();
    ds_addr = '0; ds_wdata = '0; io_addr = '0; io_wdata = '0;
    bit_set = 0; bit_addr = '0; bit_idx = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 ds_rdata in reset", ds_rdata, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_rf();
    t_io_alias();
    t_sram();
    t_oor();
    t_ioport();
    t_bitop();
    t_biterr();
    t_priority();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule